// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver Front End

This block turns the two wires of a low-speed USB link into a stream of received bytes. It runs from a clock eight times the 1.5 Mbit/s line rate. Both line inputs pass through a synchronizer. The block then waits on the idle line for the start of a packet. It locks onto the first falling edge of D- and checks the sync field. After that it samples every bit near its centre. Each D- transition pulls the sampling point back into line, so a local clock that is about one percent off still reads long packets correctly.

Each sampled bit is NRZI-decoded, and stuffed bits are removed. The remaining bits are packed into bytes, least significant bit first. Each finished byte appears on `rx_data` together with a one-cycle `rx_valid`. A single-ended zero seen at a sample point closes the packet with a one-cycle `rx_eop`. A packet longer than the configured byte limit is cut off, and `rx_overflow` pulses. CRC checks and PID decoding are left to the logic that consumes the stream.

Top module: `usb_ls_rx`

## Requirements
- R1: While reset is held and in the first cycles after it is released, `rx_valid`, `rx_eop`, `rx_overflow` and `rx_data` are all zero.
- R2: A packet starts on the idle-to-K edge (D- falls while D+ is high), followed by alternating K and J samples. The first pair of consecutive K samples ends the sync field. No sync bit is ever delivered as data.
- R3: During the sync field, two consecutive J samples send the block back to waiting for a K edge, and no byte is reported. A single-ended zero in the sync field sends it to wait for idle.
- R4: A sampled level equal to the previous bit's level decodes as 1, and a change of level decodes as 0. Bytes are packed least significant bit first. Each byte is shown on `rx_data` with `rx_valid` high for exactly one cycle.
- R5: After six consecutive decoded 1s, the next bit is dropped and not shifted in. The count of 1s starts with the final bit of the sync field.
- R6: Every D- transition restarts the bit phase, and the bit is sampled OVERSAMPLE/2 clocks later. Packets sent 1% slower or faster than nominal decode without error.
- R7: A sample with both D+ and D- low ends the packet. `rx_eop` pulses for one cycle, and any bits of an incomplete byte are discarded.
- R8: At most MAX_BYTES bytes are reported per packet. When one more byte completes, it is not reported, `rx_overflow` pulses once, and no `rx_eop` follows for that packet. The rest of the packet is ignored until a single-ended zero and then idle have been seen, and the next packet then decodes normally.
- R9: `rx_valid`, `rx_eop` and `rx_overflow` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, OVERSAMPLE times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| usb_dp | input | 1 | D+ line level, asynchronous |
| usb_dm | input | 1 | D- line level, asynchronous |
| rx_data | output | 8 | Last completed byte |
| rx_valid | output | 1 | One-cycle strobe marking a new byte on `rx_data` |
| rx_eop | output | 1 | One-cycle strobe at the end of a packet |
| rx_overflow | output | 1 | One-cycle strobe when a packet exceeds MAX_BYTES |

## Verification
The assertions check, on every cycle, the properties that hold locally in time. The three strobes never overlap and each lasts a single cycle. The run of decoded 1s never goes past six. An overflow only fires with the byte count at its limit. A byte strobe only occurs inside the data phase. What only the bench's scenarios can show is the decoded content: the exact bytes recovered through stuffing at byte boundaries, with the clock skewed by 1% either way. The scenarios also cover the rejection of a broken sync field, the dropping of a dribble before the end of packet, and recovery after an overflow.

// File: rtl/usb_lsrx_pkg.sv
`timescale 1ns/1ps
package usb_lsrx_pkg;
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_SYNC,
    ST_DATA,
    ST_DRAIN,
    ST_WAIT_J
  } rx_state_t;

  // run of decoded ones after which a stuffed bit follows
  localparam int STUFF_RUN = 6;
endpackage

// File: rtl/usb_lsrx_sync.sv
`timescale 1ns/1ps
module usb_lsrx_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      logic [WIDTH-1:0] din;
      logic [WIDTH-1:0] flop_q;
      if (i == 0) begin : g_first
        assign din = d;
      end else begin : g_rest
        assign din = g_stage[i-1].flop_q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flop_q <= RST_VAL;
        else        flop_q <= din;
      end
    end
  endgenerate

  assign q = g_stage[STAGES-1].flop_q;
endmodule

// File: rtl/usb_lsrx_phase.sv
`timescale 1ns/1ps
module usb_lsrx_phase #(
  parameter int OVERSAMPLE = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dm_s,
  output logic dm_edge,
  output logic bit_strobe
);
  localparam int CW        = $clog2(OVERSAMPLE);
  localparam int SAMPLE_AT = OVERSAMPLE / 2;

  logic          dm_q;
  logic [CW-1:0] cnt_q, cnt_d;

  assign dm_edge    = dm_s ^ dm_q;
  assign bit_strobe = !dm_edge && (cnt_q == CW'(SAMPLE_AT));

  // the edge cycle counts as phase 0, so the next cycle is phase 1
  always_comb begin
    if (dm_edge)                           cnt_d = CW'(1);
    else if (cnt_q == CW'(OVERSAMPLE - 1)) cnt_d = '0;
    else                                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dm_q  <= 1'b1;
      cnt_q <= '0;
    end else begin
      dm_q  <= dm_s;
      cnt_q <= cnt_d;
    end
  end

  assert_strobe_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |=> !bit_strobe);
  assert_edge_realigns_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dm_edge |=> !bit_strobe);
endmodule

// File: rtl/usb_lsrx_decoder.sv
`timescale 1ns/1ps
module usb_lsrx_decoder
  import usb_lsrx_pkg::*;
#(
  parameter int MAX_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dp_s,
  input  logic       dm_s,
  input  logic       dm_edge,
  input  logic       bit_strobe,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_eop,
  output logic       rx_overflow
);
  localparam int BCW = $clog2(MAX_BYTES + 1);
  localparam int OCW = $clog2(STUFF_RUN + 1);

  rx_state_t      st_q, st_d;
  logic           lvl_q, lvl_d;
  logic [OCW-1:0] ones_q, ones_d;
  logic [2:0]     bit_q, bit_d;
  logic [7:0]     sh_q, sh_d;
  logic [BCW-1:0] byte_q, byte_d;
  logic [7:0]     data_d;
  logic           valid_d, eop_d, ovf_d;
  logic           line_se0, line_j, nrzi_bit;

  assign line_se0 = !dp_s && !dm_s;
  assign line_j   = dm_s && !dp_s;
  assign nrzi_bit = (dm_s == lvl_q);

  always_comb begin
    st_d    = st_q;
    lvl_d   = lvl_q;
    ones_d  = ones_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    byte_d  = byte_q;
    data_d  = rx_data;
    valid_d = 1'b0;
    eop_d   = 1'b0;
    ovf_d   = 1'b0;
    unique case (st_q)
      ST_HUNT: begin
        if (dm_edge && !dm_s && dp_s) begin
          st_d  = ST_SYNC;
          lvl_d = 1'b1;
        end
      end
      ST_SYNC: begin
        if (bit_strobe) begin
          if (line_se0) begin
            st_d = ST_WAIT_J;
          end else if (dm_s == lvl_q) begin
            if (!dm_s) begin
              st_d   = ST_DATA;
              ones_d = OCW'(1);
              bit_d  = '0;
              byte_d = '0;
            end else begin
              st_d = ST_HUNT;
            end
          end else begin
            lvl_d = dm_s;
          end
        end
      end
      ST_DATA: begin
        if (bit_strobe) begin
          if (line_se0) begin
            eop_d = 1'b1;
            st_d  = ST_WAIT_J;
          end else begin
            lvl_d = dm_s;
            if (ones_q == OCW'(STUFF_RUN)) begin
              ones_d = '0;
            end else begin
              ones_d = nrzi_bit ? ones_q + 1'b1 : '0;
              sh_d   = {nrzi_bit, sh_q[7:1]};
              bit_d  = bit_q + 1'b1;
              if (bit_q == 3'd7) begin
                if (byte_q == BCW'(MAX_BYTES)) begin
                  ovf_d = 1'b1;
                  st_d  = ST_DRAIN;
                end else begin
                  valid_d = 1'b1;
                  data_d  = sh_d;
                  byte_d  = byte_q + 1'b1;
                end
              end
            end
          end
        end
      end
      ST_DRAIN: begin
        if (line_se0) st_d = ST_WAIT_J;
      end
      ST_WAIT_J: begin
        if (line_j) st_d = ST_HUNT;
      end
      default: st_d = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_HUNT;
      lvl_q       <= 1'b1;
      ones_q      <= '0;
      bit_q       <= '0;
      sh_q        <= '0;
      byte_q      <= '0;
      rx_data     <= '0;
      rx_valid    <= 1'b0;
      rx_eop      <= 1'b0;
      rx_overflow <= 1'b0;
    end else begin
      st_q        <= st_d;
      lvl_q       <= lvl_d;
      ones_q      <= ones_d;
      bit_q       <= bit_d;
      sh_q        <= sh_d;
      byte_q      <= byte_d;
      rx_data     <= data_d;
      rx_valid    <= valid_d;
      rx_eop      <= eop_d;
      rx_overflow <= ovf_d;
    end
  end

  assert_data_in_packet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> st_q == ST_DATA);
  assert_valid_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  assert_ones_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= OCW'(STUFF_RUN));
  assert_eop_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eop |-> st_q == ST_WAIT_J);
  assert_overflow_at_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |-> byte_q == BCW'(MAX_BYTES));
  assert_strobes_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rx_valid, rx_eop, rx_overflow}));
endmodule

// File: rtl/usb_ls_rx.sv
`timescale 1ns/1ps
module usb_ls_rx #(
  parameter int OVERSAMPLE = 8,
  parameter int MAX_BYTES  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       usb_dp,
  input  logic       usb_dm,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       rx_eop,
  output logic       rx_overflow
);
  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  logic [1:0] line_s;
  logic       dm_edge, bit_strobe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  // bit 1 = D+, bit 0 = D-, reset to the idle level
  usb_lsrx_sync #(.WIDTH(2), .STAGES(2), .RST_VAL(2'b01)) u_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d     ({usb_dp, usb_dm}),
    .q     (line_s)
  );

  usb_lsrx_phase #(.OVERSAMPLE(OVERSAMPLE)) u_phase (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .dm_s       (line_s[0]),
    .dm_edge    (dm_edge),
    .bit_strobe (bit_strobe)
  );

  usb_lsrx_decoder #(.MAX_BYTES(MAX_BYTES)) u_dec (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .dp_s        (line_s[1]),
    .dm_s        (line_s[0]),
    .dm_edge     (dm_edge),
    .bit_strobe  (bit_strobe),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .rx_eop      (rx_eop),
    .rx_overflow (rx_overflow)
  );
endmodule

// File: tb/tb_usb_ls_rx.sv
`timescale 1ns/1ps
module tb_usb_ls_rx;
  localparam real CLK_PERIOD = 10.0;
  localparam real BIT_NS     = CLK_PERIOD * 8.0;
  localparam int  MAXB       = 8;
  localparam int  NV         = 5;

  // payload (byte 0 in bits 7:0), byte count, rate offset in tenths of a percent
  localparam logic [63:0] V_PAY [NV] = '{
    64'h0000_0000_00FF_A52D,
    64'h0000_0000_7E3F_FFC1,
    64'h0000_0000_0000_0000,
    64'h0000_0000_0000_801F,
    64'h0123_4567_89AB_CDEF
  };
  localparam int V_LEN  [NV] = '{3, 4, 4, 2, 8};
  localparam int V_SKEW [NV] = '{0, 10, -10, 0, 10};

  logic       clk, rst_n, usb_dp, usb_dm;
  logic [7:0] rx_data;
  logic       rx_valid, rx_eop, rx_overflow;

  int         n_checks, n_fail;
  int         n_valid, n_eop, n_ovf, n_multi;
  logic [7:0] got [16];
  logic       lvl;
  int         ones;

  usb_ls_rx #(.OVERSAMPLE(8), .MAX_BYTES(MAXB)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .usb_dp      (usb_dp),
    .usb_dm      (usb_dm),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .rx_eop      (rx_eop),
    .rx_overflow (rx_overflow)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2.0) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        if (n_valid < 16) got[n_valid] = rx_data;
        n_valid++;
      end
      if (rx_eop) n_eop++;
      if (rx_overflow) n_ovf++;
      if ($countones({rx_valid, rx_eop, rx_overflow}) > 1) n_multi++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic clear_counts();
    n_valid = 0; n_eop = 0; n_ovf = 0;
  endtask

  task automatic drive_lvl(input real bt);
    usb_dm = lvl;
    usb_dp = !lvl;
    #(bt);
  endtask

  task automatic tx_bit(input logic b, input real bt);
    if (!b) lvl = !lvl;
    drive_lvl(bt);
    if (b) begin
      ones++;
      if (ones == 6) begin
        lvl = !lvl;
        drive_lvl(bt);
        ones = 0;
      end
    end else begin
      ones = 0;
    end
  endtask

  task automatic end_packet(input real bt);
    usb_dp = 1'b0; usb_dm = 1'b0;
    #(2.0 * bt);
    lvl = 1'b1;
    drive_lvl(4.0 * bt);
  endtask

  task automatic send_pkt(input logic [63:0] pay, input int nbytes, input int extra, input real bt);
    ones = 0;
    for (int i = 0; i < 7; i++) tx_bit(1'b0, bt);
    tx_bit(1'b1, bt);
    for (int i = 0; i < nbytes * 8; i++) tx_bit(pay[i], bt);
    for (int i = 0; i < extra; i++) tx_bit((i % 3) != 0, bt);
    end_packet(bt);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000.0);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    n_checks = 0; n_fail = 0; n_multi = 0;
    clear_counts();
    lvl = 1'b1;
    usb_dm = 1'b1; usb_dp = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1 valid in reset", int'(rx_valid), 0);
    chk("R1 eop in reset", int'(rx_eop), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 data after reset", int'(rx_data), 0);
    chk("R1 overflow after reset", int'(rx_overflow), 0);
    #(4.0 * BIT_NS);

    // table of packets: R2 R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      automatic real bt = BIT_NS * (1000.0 + real'(V_SKEW[v])) / 1000.0;
      clear_counts();
      send_pkt(V_PAY[v], V_LEN[v], 0, bt);
      chk($sformatf("R2 R6 byte count vec %0d", v), n_valid, V_LEN[v]);
      for (int k = 0; k < V_LEN[v]; k++)
        chk($sformatf("R4 R5 byte %0d vec %0d", k, v), int'(got[k]), int'(V_PAY[v][8*k +: 8]));
      chk($sformatf("R7 eop vec %0d", v), n_eop, 1);
      chk($sformatf("R8 no overflow vec %0d", v), n_ovf, 0);
    end

    // R7: dribble of three bits before SE0 is dropped
    clear_counts();
    send_pkt(64'h5A, 1, 3, BIT_NS);
    chk("R7 dribble byte count", n_valid, 1);
    chk("R7 dribble byte", int'(got[0]), 'h5A);
    chk("R7 dribble eop", n_eop, 1);

    // R3: K then two J bits is not a sync
    clear_counts();
    lvl = 1'b0; drive_lvl(BIT_NS);
    lvl = 1'b1; drive_lvl(6.0 * BIT_NS);
    chk("R3 false sync bytes", n_valid, 0);
    chk("R3 false sync eop", n_eop, 0);
    send_pkt(64'hC3, 1, 0, BIT_NS);
    chk("R3 recovery byte count", n_valid, 1);
    chk("R3 recovery byte", int'(got[0]), 'hC3);

    // R8: one byte beyond the limit, with extra bits after it
    clear_counts();
    send_pkt(64'hF0E1_D2C3_B4A5_9687, MAXB, 12, BIT_NS);
    chk("R8 bytes up to limit", n_valid, MAXB);
    chk("R8 last kept byte", int'(got[MAXB-1]), 'hF0);
    chk("R8 overflow pulse", n_ovf, 1);
    chk("R8 no eop after overflow", n_eop, 0);
    clear_counts();
    send_pkt(64'h3C, 1, 0, BIT_NS);
    chk("R8 next packet byte", int'(got[0]), 'h3C);
    chk("R8 next packet eop", n_eop, 1);

    // R9: strobes never overlapped
    chk("R9 overlapping strobes", n_multi, 0);
    finish_run();
  end
endmodule